// File: doc/BRIEF.md
# Recirculating Serial Accumulator Ring

This block is a long serial bit store arranged as a closed ring. On each cycle where the shift strobe is high, every stage moves one place toward the tail. The bit leaving the tail returns to the head. In recirculate mode that bit re-enters unchanged, so a stored frame rotates without loss. In write mode the entering bit is the serial input XORed with the bit leaving the tail. On a cleared ring one such pass loads a frame. Further passes add new frames bitwise, modulo 2.

A read control gates the serial output. When the output is disabled, the data line is held low and a separate enable output is low. Several rings can therefore share one wired-OR line, with each one modelled as a three-state driver. A synchronous clear empties the ring. A position counter marks the cycle in which the frame's first bit sits at the tail, so the host can line up with frame boundaries.

Top module: `serial_ring_accum`

## Requirements
- R1: The ring holds DEPTH bits (default 1024). On a shift with write_i low, the tail bit re-enters at the head unchanged, so DEPTH shifts restore the original contents.
- R2: On a shift with write_i high, the bit entering the head is data_i XOR the bit leaving the tail.
- R3: While shift_en_i is low and clear_i is low, no stage changes, whatever write_i and data_i are.
- R4: clear_i high at a clock edge sets every stage to 0 and the position count to 0. It takes priority over a shift in the same cycle.
- R5: Asynchronous reset (rst_ni low) sets every stage to 0 and the position count to 0.
- R6: data_oe_o equals read_i. data_o is the tail bit when read_i is 1 and 0 when read_i is 0.
- R7: The tail bit shown on data_o changes only at a clock edge where a shift or a clear takes place.
- R8: frame_o is 1 exactly when the number of shifts since the last reset or clear is a multiple of DEPTH.
- R9: Read control and write control act independently. All four combinations of write_i and read_i behave as R1, R2 and R6 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shift_en_i | input | 1 | Advance the ring by one stage |
| write_i | input | 1 | 1: XOR input into the ring; 0: recirculate |
| read_i | input | 1 | 1: drive the tail bit onto the output |
| data_i | input | 1 | Serial data in |
| clear_i | input | 1 | Synchronous clear of the ring and position |
| data_o | output | 1 | Tail bit when enabled, else 0 |
| data_oe_o | output | 1 | Output driver enable |
| frame_o | output | 1 | Frame start bit is at the tail |

## Verification
A clear and a shift can fall in the same cycle, and in that cycle the clear must win. The bench drives clear_i together with shift_en_i, write_i and data_i high, both mid-frame and on a frame boundary. It expects an all-zero ring and frame_o high on the next cycle. A full recirculating pass after that is read out and compared with the bench's queue model bit by bit, so that any bit the shift wrote would show up.

// File: rtl/srr_pkg.sv
package srr_pkg;
  parameter int unsigned DEFAULT_DEPTH = 1024;
  typedef enum logic {
    ENTRY_RECIRC = 1'b0,
    ENTRY_XOR    = 1'b1
  } entry_e;
endpackage

// File: rtl/srr_head.sv
module srr_head
  import srr_pkg::*;
(
  input  logic write_i,
  input  logic data_i,
  input  logic tail_i,
  output logic head_o
);
  entry_e sel;
  assign sel = write_i ? ENTRY_XOR : ENTRY_RECIRC;

  always_comb begin
    unique case (sel)
      ENTRY_XOR:    head_o = data_i ^ tail_i;
      default:      head_o = tail_i;
    endcase
  end
endmodule

// File: rtl/srr_ring.sv
module srr_ring #(
  parameter int unsigned DEPTH = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic shift_i,
  input  logic head_i,
  output logic tail_o,
  output logic head_stage_o
);
  logic [DEPTH-1:0] stage_q;

  for (genvar j = 0; j < DEPTH; j++) begin : g_stage
    logic nxt;
    if (j == DEPTH - 1) begin : g_head
      assign nxt = head_i;
    end else begin : g_body
      assign nxt = stage_q[j+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stage_q[j] <= 1'b0;
      else if (clear_i) stage_q[j] <= 1'b0;
      else if (shift_i) stage_q[j] <= nxt;
    end
  end

  assign tail_o       = stage_q[0];
  assign head_stage_o = stage_q[DEPTH-1];

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !shift_i) |=> $stable(stage_q));

  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (stage_q == '0));
endmodule

// File: rtl/srr_pos.sv
module srr_pos #(
  parameter int unsigned DEPTH = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic shift_i,
  output logic frame_o
);
  localparam int unsigned PosW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PosW-1:0] PosLast = PosW'(DEPTH - 1);

  logic [PosW-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pos_q <= '0;
    else if (clear_i) pos_q <= '0;
    else if (shift_i) pos_q <= (pos_q == PosLast) ? '0 : pos_q + 1'b1;
  end

  assign frame_o = (pos_q == '0);

  assert_frame_leave_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_o && shift_i && !clear_i) |=> !frame_o);

  assert_frame_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !clear_i) |=> $stable(frame_o));
endmodule

// File: rtl/srr_out.sv
module srr_out (
  input  logic read_i,
  input  logic tail_i,
  output logic data_o,
  output logic data_oe_o
);
  // Disabled driver pulls nothing: 0 on a wired-OR line
  assign data_oe_o = read_i;
  assign data_o    = read_i & tail_i;
endmodule

// File: rtl/serial_ring_accum.sv
module serial_ring_accum
  import srr_pkg::*;
#(
  parameter int unsigned DEPTH = DEFAULT_DEPTH
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_en_i,
  input  logic write_i,
  input  logic read_i,
  input  logic data_i,
  input  logic clear_i,
  output logic data_o,
  output logic data_oe_o,
  output logic frame_o
);
  logic tail, head_bit, head_stage;

  srr_head u_head (
    .write_i (write_i),
    .data_i  (data_i),
    .tail_i  (tail),
    .head_o  (head_bit)
  );

  srr_ring #(.DEPTH(DEPTH)) u_ring (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (clear_i),
    .shift_i      (shift_en_i),
    .head_i       (head_bit),
    .tail_o       (tail),
    .head_stage_o (head_stage)
  );

  srr_pos #(.DEPTH(DEPTH)) u_pos (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .shift_i (shift_en_i),
    .frame_o (frame_o)
  );

  srr_out u_out (
    .read_i    (read_i),
    .tail_i    (tail),
    .data_o    (data_o),
    .data_oe_o (data_oe_o)
  );

  assert_recirc_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en_i && !write_i && !clear_i) |=> (head_stage == $past(tail)));

  assert_write_xor_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en_i && write_i && !clear_i) |=> (head_stage == ($past(data_i) ^ $past(tail))));

  assert_oe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_o |-> data_oe_o);

  assert_clear_frame_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (frame_o && !data_o));
endmodule

// File: tb/serial_ring_accum_test.sv
module serial_ring_accum_test;
  localparam int DEPTH = 1024;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic shift_en_i = 1'b0, write_i = 1'b0, read_i = 1'b0, data_i = 1'b0, clear_i = 1'b0;
  logic data_o, data_oe_o, frame_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit q[$];
  int pos = 0;
  bit pat_a[DEPTH];
  bit pat_b[DEPTH];

  always #2.5 clk_i = ~clk_i;

  serial_ring_accum #(.DEPTH(DEPTH)) uut (
    .clk_i, .rst_ni, .shift_en_i, .write_i, .read_i, .data_i, .clear_i,
    .data_o, .data_oe_o, .frame_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare outputs against the queue model, then clock once.
  task automatic cyc(input bit sh, input bit wr, input bit rd, input bit d,
                     input bit clr, input string tag);
    bit t;
    bit exp_d;
    shift_en_i = sh; write_i = wr; read_i = rd; data_i = d; clear_i = clr;
    #1;
    exp_d = rd ? q[0] : 1'b0;
    chk(data_oe_o == rd, "R6 oe", data_oe_o, rd);
    chk(data_o == exp_d, tag, data_o, exp_d);
    chk(frame_o == (pos == 0), "R8 frame", frame_o, pos == 0);
    @(posedge clk_i);
    if (clr) begin
      foreach (q[k]) q[k] = 1'b0;
      pos = 0;
    end else if (sh) begin
      t = q.pop_front();
      q.push_back(wr ? (d ^ t) : t);
      pos = (pos + 1) % DEPTH;
    end
    @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      q.push_back(1'b0);
      pat_a[i] = 1'($urandom_range(0, 1));
      pat_b[i] = 1'($urandom_range(0, 1));
    end
    pat_a[0] = 1'b1;
    repeat (3) @(negedge clk_i);
    // R5: reset state
    #1;
    chk(data_oe_o == 1'b0, "R5 oe in reset", data_oe_o, 0);
    chk(frame_o == 1'b1, "R5 frame in reset", frame_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 tail zero");

    // R2: load pattern A by one XOR pass, read off (R9 combo 10)
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, 1'b1, 1'b0, pat_a[i], 1'b0, "R2 load no read");
    // R1: recirculate with read on (R9 combo 01)
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R1 recirc");
    // R3: hold, write/data toggled
    for (int i = 0; i < 20; i++) cyc(1'b0, 1'($urandom_range(0, 1)), 1'b1, 1'($urandom_range(0, 1)), 1'b0, "R3 hold");
    // R2: accumulate B with read on (R9 combo 11)
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, 1'b1, 1'b1, pat_b[i], 1'b0, "R2 accumulate");
    // R1/R7: partial rotation with strobe gaps, read off then on (combo 00)
    for (int i = 0; i < 300; i++) cyc(1'($urandom_range(0, 1)), 1'b0, 1'(i % 2), 1'b0, 1'b0, "R7 gapped recirc");
    // R4: clear colliding with a write shift, mid-frame
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R4 clear vs shift");
    chk(frame_o == 1'b1, "R4 frame after clear", frame_o, 1);
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R4 ring empty");
    // R4 on a frame boundary, after a fresh load
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, 1'b1, 1'b1, pat_b[i], 1'b0, "R2 reload");
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R4 clear at boundary");
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R4 ring empty 2");
    // R5: asynchronous reset mid-stream
    for (int i = 0; i < 50; i++) cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R2 fill ones");
    #1 rst_ni = 1'b0;
    foreach (q[k]) q[k] = 1'b0;
    pos = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R5 empty after reset");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule